// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits on the processor side, between a 32-bit register file and a 32-bit memory bus that is split into four byte lanes. On the store side it takes the register value and the access size. It places byte, halfword or word data on the bus lanes and raises a byte-lane enable for each lane that memory should write. On the load side it takes the 32-bit word returned by the bus and the two low address bits. From these it forms the register value. A byte or halfword load is picked from its lanes and zero-extended. An unaligned word load is rotated and does not fault.

A static endian-select input sets the lane numbering. In little-endian mode the lowest address is lane 0. In big-endian mode the lowest address is the most significant lane, so every lane choice is mirrored. A misaligned halfword access is defined, not left open: address bit 0 is ignored and a flag is raised. One parameter adds a single output register stage. Without it the path is purely combinational.

Top module: `lane_aligner`

## Requirements
- R1: The size input is coded 00 = byte, 01 = halfword, 10 = word and 11 = reserved. A reserved access drives store data 0, lane enables 0000, load data 0 and misaligned flag 0.
- R2: A word store drives the register value unchanged on the bus, so register bit 31 drives bus bit 31. All four lane enables are 1111 for any address bits and either endian mode.
- R3: A byte store copies register bits 7:0 onto all four lanes. Exactly one lane enable is set. It is lane A[1:0] in little-endian mode and lane 3 minus A[1:0] in big-endian mode. Lane enable bit i guards bus bits 8i+7:8i.
- R4: A halfword store copies register bits 15:0 onto both bus halves. In little-endian mode the enables are 0011 when A[1]=0 and 1100 when A[1]=1. Big-endian mode mirrors this: 1100 when A[1]=0 and 0011 when A[1]=1.
- R5: A little-endian byte load returns bus lane A[1:0] (bits 8*A+7:8*A), zero-extended to 32 bits.
- R6: A big-endian byte load returns bus lane 3 minus A[1:0], zero-extended to 32 bits.
- R7: A halfword load returns bus bits 15:0 or 31:16, zero-extended. In little-endian mode it is 15:0 when A[1]=0 and 31:16 when A[1]=1. Big-endian mode is the other way round.
- R8: A little-endian word load rotates the bus word right by 8*A[1:0] bits. For bus 0x76543210, offsets 0 to 3 give 0x76543210, 0x10765432, 0x32107654 and 0x54321076.
- R9: A big-endian word load rotates the bus word left by 8*A[1:0] bits, so an aligned load is unchanged. For bus 0x76543210, offset 1 gives 0x54321076.
- R10: The misaligned flag is 1 exactly for a halfword access with A[0]=1. In that case every output is the same as for the access with A[0]=0.
- R11: With REG_OUT=1 every output appears one clock after its inputs and is 0 while rstN is low. With REG_OUT=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| bigEndian | input | 1 | 1 selects big-endian lane numbering, 0 selects little-endian |
| accSize | input | 2 | Access size code (see R1) |
| addrLow | input | 2 | Low address bits A[1:0] |
| storeReg | input | 32 | Register value to be stored |
| busRdata | input | 32 | Word returned by the memory bus |
| busWdata | output | 32 | Lane-replicated store data |
| laneEn | output | 4 | Byte-lane write enables |
| loadData | output | 32 | Aligned, zero-extended load result |
| misaligned | output | 1 | Halfword access with A[0]=1 |

## Verification
The store lane drive and the load lane extraction work in the same cycle from one decode of size, offset and endian mode. Store data and bus data are independent inputs. Each vector therefore drives an unrelated register value and bus word together, and both the store outputs and the load result are judged against the bench's arithmetic model in that same cycle. A fault in the shared decode, such as a lane index that is mirrored in one path and not the other, shows up as a mismatch on one side even when the other side is correct. The sweep covers every size code, every offset and both endian modes, on a registered instance and on a combinational instance side by side.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = DATA_W / LANE_W;
  localparam int unsigned OFF_W   = $clog2(LANES);
  localparam int unsigned HALF_W  = 2 * LANE_W;
  localparam int unsigned HALVES  = DATA_W / HALF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             selByte;
    logic             selHalf;
    logic             selWord;
    logic [OFF_W-1:0] byteLane;   // lane holding the addressed byte
    logic [OFF_W-1:0] halfLane;   // lower lane of the addressed halfword
    logic [OFF_W-1:0] rotRight;   // right rotation of bus word, in lanes
    logic [LANES-1:0] laneEn;
    logic             misaligned;
  } laneCtl_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bigEndian,
  input  logic [1:0]       accSize,
  input  logic [OFF_W-1:0] addrLow,
  output laneCtl_t         ctl
);
  accSize_e         sizeCode;
  logic [OFF_W-1:0] halfBase;
  logic [OFF_W-1:0] leByte;
  logic [OFF_W-1:0] beByte;
  logic [OFF_W-1:0] beHalf;

  always_comb begin
    sizeCode = accSize_e'(accSize);
    halfBase = {addrLow[OFF_W-1:1], 1'b0};
    leByte   = addrLow;
    beByte   = OFF_W'(LANES - 1) - addrLow;
    beHalf   = OFF_W'(LANES - 2) - halfBase;

    ctl            = '0;
    ctl.selByte    = (sizeCode == SZ_BYTE);
    ctl.selHalf    = (sizeCode == SZ_HALF);
    ctl.selWord    = (sizeCode == SZ_WORD);
    ctl.byteLane   = bigEndian ? beByte : leByte;
    ctl.halfLane   = bigEndian ? beHalf : halfBase;
    // big-endian rotates left, expressed as a right rotation modulo LANES
    ctl.rotRight   = bigEndian ? (OFF_W'(0) - addrLow) : addrLow;
    ctl.misaligned = ctl.selHalf & addrLow[0];

    for (int i = 0; i < LANES; i++) begin
      unique case (sizeCode)
        SZ_BYTE: ctl.laneEn[i] = (OFF_W'(i) == ctl.byteLane);
        SZ_HALF: ctl.laneEn[i] = (OFF_W'(i) == ctl.halfLane) ||
                                 (OFF_W'(i) == ctl.halfLane + OFF_W'(1));
        SZ_WORD: ctl.laneEn[i] = 1'b1;
        default: ctl.laneEn[i] = 1'b0;
      endcase
    end
  end

  // R1: at most one size strobe, none for reserved
  p_one_size_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selByte, ctl.selHalf, ctl.selWord}));
  p_rsvd_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b11) |-> (ctl.laneEn == '0));
  // R3: byte store enables a single lane
  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selByte |-> ($countones(ctl.laneEn) == 1));
  // R4: halfword store enables two lanes
  p_half_two_lanes_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selHalf |-> ($countones(ctl.laneEn) == 2));
  // R10: flag only on halfword accesses
  p_misalign_half_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.misaligned |-> (accSize == 2'b01));
endmodule

// File: rtl/lane_dpath.sv
module lane_dpath
  import lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [DATA_W-1:0] storeReg,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] loadData
);
  logic [LANE_W-1:0] busLane [LANES];
  logic [DATA_W-1:0] byteRep;
  logic [DATA_W-1:0] halfRep;
  logic [DATA_W-1:0] rotWord;
  logic [LANE_W-1:0] byteVal;
  logic [HALF_W-1:0] halfVal;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign busLane[g]                   = busRdata[g*LANE_W +: LANE_W];
      assign byteRep[g*LANE_W +: LANE_W]  = storeReg[LANE_W-1:0];
    end
    for (g = 0; g < HALVES; g++) begin : gHalf
      assign halfRep[g*HALF_W +: HALF_W]  = storeReg[HALF_W-1:0];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < LANES; i++)
      rotWord[i*LANE_W +: LANE_W] = busLane[OFF_W'(OFF_W'(i) + ctl.rotRight)];
    byteVal = busLane[ctl.byteLane];
    halfVal = {busLane[ctl.halfLane + OFF_W'(1)], busLane[ctl.halfLane]};
  end

  always_comb begin
    busWdata = '0;
    loadData = '0;
    if (ctl.selByte) begin
      busWdata = byteRep;
      loadData = DATA_W'(byteVal);
    end else if (ctl.selHalf) begin
      busWdata = halfRep;
      loadData = DATA_W'(halfVal);
    end else if (ctl.selWord) begin
      busWdata = storeReg;
      loadData = rotWord;
    end
  end

  // R2: word store passes the register straight through with all lanes on
  p_word_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selWord |-> ((busWdata == storeReg) && (&ctl.laneEn)));
  // R3: every lane carries the stored byte
  p_byte_repl_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selByte |-> (busWdata[DATA_W-1 -: LANE_W] == storeReg[LANE_W-1:0]));
  // R5: byte loads are zero-extended
  p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selByte |-> (loadData[DATA_W-1:LANE_W] == '0));
  // R7: halfword loads are zero-extended
  p_half_zext_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selHalf |-> (loadData[DATA_W-1:HALF_W] == '0));
  // R10: misaligned halfword still yields a zero-extended halfword
  p_misalign_zext_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.misaligned |-> (loadData[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic [1:0]        accSize,
  input  logic [OFF_W-1:0]  addrLow,
  input  logic [DATA_W-1:0] storeReg,
  input  logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] busWdata,
  output logic [LANES-1:0]  laneEn,
  output logic [DATA_W-1:0] loadData,
  output logic              misaligned
);
  laneCtl_t          ctl;
  logic [DATA_W-1:0] wdataComb;
  logic [DATA_W-1:0] loadComb;

  lane_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bigEndian (bigEndian),
    .accSize   (accSize),
    .addrLow   (addrLow),
    .ctl       (ctl)
  );

  lane_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .storeReg (storeReg),
    .busRdata (busRdata),
    .busWdata (wdataComb),
    .loadData (loadComb)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          busWdata   <= '0;
          laneEn     <= '0;
          loadData   <= '0;
          misaligned <= 1'b0;
        end else begin
          busWdata   <= wdataComb;
          laneEn     <= ctl.laneEn;
          loadData   <= loadComb;
          misaligned <= ctl.misaligned;
        end
      end
      // R11: registered outputs follow the previous cycle's word-size decode
      p_reg_word_r11: assert property (@(posedge clk) disable iff (!rstN)
        (accSize == 2'b10) |=> (&laneEn));
    end else begin : gComb
      always_comb begin
        busWdata   = wdataComb;
        laneEn     = ctl.laneEn;
        loadData   = loadComb;
        misaligned = ctl.misaligned;
      end
    end
  endgenerate
endmodule

// File: tb/sim_lane_aligner.sv
`timescale 1ns/1ps
module sim_lane_aligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic [1:0]  addrLow = 2'b00;
  logic [31:0] storeReg = 32'h0;
  logic [31:0] busRdata = 32'h0;

  logic [31:0] wdR, ldR, wdC, ldC;
  logic [3:0]  enR, enC;
  logic        misR, misC;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] prevLoad = 32'h0;

  always #10 clk = ~clk;

  lane_aligner #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .accSize(accSize),
    .addrLow(addrLow), .storeReg(storeReg), .busRdata(busRdata),
    .busWdata(wdR), .laneEn(enR), .loadData(ldR), .misaligned(misR));

  lane_aligner #(.REG_OUT(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .accSize(accSize),
    .addrLow(addrLow), .storeReg(storeReg), .busRdata(busRdata),
    .busWdata(wdC), .laneEn(enC), .loadData(ldC), .misaligned(misC));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(bit be, logic [1:0] sz, int kind);
    if (sz == 2'b11) return "R1";
    if (kind == 3) return "R10";
    if (kind < 2) return (sz == 2'b10) ? "R2" : (sz == 2'b00) ? "R3" : "R4";
    if (sz == 2'b00) return be ? "R6" : "R5";
    if (sz == 2'b01) return "R7";
    return be ? "R9" : "R8";
  endfunction

  task automatic runVec(bit be, logic [1:0] sz, logic [1:0] off,
                        logic [31:0] sreg, logic [31:0] bus);
    logic [31:0] eW, eL;
    logic [3:0]  eE;
    logic        eM;
    logic [63:0] dbl;
    int          ln;
    dbl = {bus, bus};
    eM  = (sz == 2'b01) && off[0];
    case (sz)
      2'b00: begin
        ln = be ? 3 - int'(off) : int'(off);
        eW = {4{sreg[7:0]}};
        eE = 4'b0001 << ln;
        eL = {24'h0, bus[8*ln +: 8]};
      end
      2'b01: begin
        eW = {2{sreg[15:0]}};
        eE = ((off[1] ^ be) ? 4'b1100 : 4'b0011);
        eL = (off[1] ^ be) ? {16'h0, bus[31:16]} : {16'h0, bus[15:0]};
      end
      2'b10: begin
        eW = sreg;
        eE = 4'b1111;
        if (be) eL = dbl[63 - 8*int'(off) -: 32];
        else    eL = dbl[8*int'(off) +: 32];
      end
      default: begin
        eW = 32'h0; eE = 4'h0; eL = 32'h0;
      end
    endcase

    @(negedge clk);
    bigEndian = be; accSize = sz; addrLow = off; storeReg = sreg; busRdata = bus;
    #1;
    chk("R11", "reg load before edge", ldR, prevLoad);
    chk(reqOf(be, sz, 0), "comb wdata", wdC, eW);
    chk(reqOf(be, sz, 1), "comb laneEn", {28'h0, enC}, {28'h0, eE});
    chk(reqOf(be, sz, 2), "comb load", ldC, eL);
    chk(reqOf(be, sz, 3), "comb misaligned", {31'h0, misC}, {31'h0, eM});
    @(posedge clk);
    #1;
    chk(reqOf(be, sz, 0), "reg wdata", wdR, eW);
    chk(reqOf(be, sz, 1), "reg laneEn", {28'h0, enR}, {28'h0, eE});
    chk(reqOf(be, sz, 2), "reg load", ldR, eL);
    chk(reqOf(be, sz, 3), "reg misaligned", {31'h0, misR}, {31'h0, eM});
    prevLoad = eL;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: outputs held at zero under reset, even with active inputs
    accSize = 2'b10; storeReg = 32'hDEADBEEF; busRdata = 32'h12345678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset wdata", wdR, 32'h0);
    chk("R11", "reset laneEn", {28'h0, enR}, 32'h0);
    chk("R11", "reset load", ldR, 32'h0);
    chk("R11", "reset misaligned", {31'h0, misR}, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #1;
    prevLoad = 32'h12345678;

    // R8 / R9: worked example values
    runVec(1'b0, 2'b10, 2'd1, 32'h0, 32'h76543210);
    chk("R8", "example off1", ldC, 32'h10765432);
    runVec(1'b0, 2'b10, 2'd3, 32'h0, 32'h76543210);
    chk("R8", "example off3", ldC, 32'h54321076);
    runVec(1'b1, 2'b10, 2'd1, 32'h0, 32'h76543210);
    chk("R9", "example off1", ldC, 32'h54321076);

    // full sweep: endian x size x offset x data patterns (R1..R10)
    for (int p = 0; p < 6; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < 4; s++) begin
          for (int o = 0; o < 4; o++) begin
            logic [31:0] sr, bw;
            sr = 32'h9E3779B9 * (p + 1) ^ 32'h0F1E2D3C;
            bw = (p == 0) ? 32'h76543210 : (32'h85EBCA6B * (p + 3)) ^ {p[7:0], 24'hA5C3E1};
            runVec(e[0], s[1:0], o[1:0], sr, bw);
          end
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule